// File: doc/BRIEF.md
# Reset Sequencer with Watchdog Source

This block produces the internal system reset of a small microcontroller from two sources: an active-low external reset pin and a single-cycle reset request from a watchdog timer. A low level on the pin forces the reset outputs low at once, with no clock edge involved. Release is clean and follows the master clock: a short synchroniser chain lets reset go away only on a rising clock edge. A watchdog request puts the same core and peripheral resets low for a fixed number of cycles.

After either kind of release, the block counts a fixed delay before it raises the fetch-enable that lets the processor begin. On the first fetch cycle it also raises a one-cycle flag that tells the processor to fetch from address zero. The boot-mode and tri-state configuration straps are sampled only when a pin reset is released. A watchdog reset keeps the values already latched. A two-bit cause register records which source caused the latest reset.

Top module: `rst_seq_top`

## Requirements
- R1: While `ext_rst_n` is low, `core_rst_n`, `periph_rst_n` and `fetch_en` are low. They go low as soon as the pin falls, without waiting for a clock edge.
- R2: After `ext_rst_n` rises, `core_rst_n` and `periph_rst_n` stay low through the first rising clock edge and go high on the second.
- R3: After a pin reset, `fetch_en` rises on the 80th rising clock edge after `ext_rst_n` rises, and it is low before that edge.
- R4: A one-cycle `wdt_req` pulse, sampled while `core_rst_n` is high, drives `core_rst_n` and `periph_rst_n` low from the next edge for exactly 16 cycles, with `fetch_en` low.
- R5: After a watchdog reset is released, `fetch_en` rises on the 80th rising edge after the release edge.
- R6: On a pin reset, `boot_mode` and `tri_mode` take the levels of `strap_boot` and `strap_tri` at the clock edge where reset is released. Later changes on the strap pins have no effect on them.
- R7: A watchdog reset leaves `boot_mode` and `tri_mode` unchanged, whatever the strap pins show.
- R8: When `ext_rst_n` is low in the same cycle as a `wdt_req` pulse, the event counts as a pin reset: the cause reads 01 and the straps are sampled at release.
- R9: `rst_cause` reads 2'b01 after a pin reset and 2'b10 after a watchdog reset. Once the pin has been asserted, it never reads 00 or 11.
- R10: `fetch_zero` is high only in the first cycle in which `fetch_en` is high, and it lasts for one cycle only.
- R11: A new reset of either kind that arrives while the fetch delay is running restarts the whole sequence from that reset. The pending fetch-enable does not appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_req | input | 1 | Watchdog reset request, one-cycle pulse, synchronous to clk |
| strap_boot | input | 1 | Boot-mode strap pin level |
| strap_tri | input | 1 | Tri-state strap pin level |
| core_rst_n | output | 1 | Processor core reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| fetch_en | output | 1 | Processor may start fetching |
| fetch_zero | output | 1 | One-cycle flag: first fetch is from address zero |
| boot_mode | output | 1 | Latched boot-mode strap |
| tri_mode | output | 1 | Latched tri-state strap |
| rst_cause | output | 2 | Cause of the last reset: 01 pin, 10 watchdog |

## Verification
Each stimulus pattern separates one behaviour from its neighbours:
- A plain pin reset, where the strap pins change after release, separates capture at the release edge from continuous sampling.
- A lone watchdog pulse, with strap pins that differ from the latched values, shows whether the straps are protected and whether the hold and delay lengths are exact.
- A second watchdog pulse during a running fetch delay, followed by a pin drop together with a watchdog pulse during another delay, shows restart behaviour and pin priority.
- For each pattern, the edges on both sides of every transition are sampled, so an off-by-one in the synchroniser, the hold count or the fetch count is caught.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;

  typedef enum logic [1:0] {
    SQ_DELAY = 2'd0,
    SQ_WHOLD = 2'd1,
    SQ_BOOT  = 2'd2,
    SQ_RUN   = 2'd3
  } seq_state_e;

  typedef logic [1:0] cause_t;

  localparam cause_t CAUSE_PIN = 2'b01;
  localparam cause_t CAUSE_WDT = 2'b10;

endpackage

// File: rtl/rst_seq_sync.sv
`timescale 1ns/1ps
// Reset synchroniser: asserts asynchronously, releases after STAGES edges.
module rst_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o,
  output logic release_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_o   = sh_q[STAGES-1];
  // high for the one cycle whose closing edge releases reset
  assign release_o = sh_q[STAGES-2] & ~sh_q[STAGES-1];

endmodule

// File: rtl/rst_seq_strap.sv
`timescale 1ns/1ps
// Strap capture: plain enabled flops, deliberately without reset so a
// watchdog reset cannot disturb them.
module rst_seq_strap #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] held_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (cap_en) begin
        held_o[i] <= pins_i[i];
      end
    end
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
`timescale 1ns/1ps
// Sequencing state machine: watchdog hold, fetch delay, boot, run.
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WDT_HOLD    = 16,
  parameter int FETCH_DELAY = 80
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wdt_req,
  output logic   hold_n_o,
  output logic   fetch_en_o,
  output logic   fetch_zero_o,
  output cause_t cause_o
);

  localparam int MAX_CNT = (FETCH_DELAY > WDT_HOLD) ? FETCH_DELAY : WDT_HOLD;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] CNT_PRELOAD = CNT_W'(SYNC_STAGES);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(WDT_HOLD - 1);
  localparam logic [CNT_W-1:0] DELAY_LAST  = CNT_W'(FETCH_DELAY - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cause_t           cause_q, cause_d;
  logic             cnt_en, cause_en;

  // next state
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    cause_d  = cause_q;
    cnt_en   = 1'b0;
    cause_en = 1'b0;
    if (wdt_req) begin
      st_d     = SQ_WHOLD;
      cnt_d    = '0;
      cnt_en   = 1'b1;
      cause_d  = CAUSE_WDT;
      cause_en = 1'b1;
    end else begin
      unique case (st_q)
        SQ_WHOLD: begin
          cnt_en = 1'b1;
          if (cnt_q == HOLD_LAST) begin
            st_d  = SQ_DELAY;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SQ_DELAY: begin
          cnt_en = 1'b1;
          if (cnt_q == DELAY_LAST) begin
            st_d = SQ_BOOT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SQ_BOOT: st_d = SQ_RUN;
        SQ_RUN:  st_d = SQ_RUN;
        default: st_d = SQ_DELAY;
      endcase
    end
  end

  // registers; counter preloaded with the cycles spent in the synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_DELAY;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_PRELOAD;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_PIN;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  assign hold_n_o     = (st_q != SQ_WHOLD);
  assign fetch_en_o   = (st_q == SQ_BOOT) || (st_q == SQ_RUN);
  assign fetch_zero_o = (st_q == SQ_BOOT);
  assign cause_o      = cause_q;

endmodule

// File: rtl/rst_seq_top.sv
`timescale 1ns/1ps
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WDT_HOLD    = 16,
  parameter int FETCH_DELAY = 80
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic       wdt_req,
  input  logic       strap_boot,
  input  logic       strap_tri,
  output logic       core_rst_n,
  output logic       periph_rst_n,
  output logic       fetch_en,
  output logic       fetch_zero,
  output logic       boot_mode,
  output logic       tri_mode,
  output logic [1:0] rst_cause
);

  localparam int NUM_STRAPS = 2;

  logic                  sync_rst_n;
  logic                  sync_release;
  logic                  hold_n;
  logic [NUM_STRAPS-1:0] strap_pins;
  logic [NUM_STRAPS-1:0] strap_held;
  cause_t                cause;

  rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .arst_n    (ext_rst_n),
    .rst_n_o   (sync_rst_n),
    .release_o (sync_release)
  );

  rst_seq_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .WDT_HOLD    (WDT_HOLD),
    .FETCH_DELAY (FETCH_DELAY)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (sync_rst_n),
    .wdt_req      (wdt_req),
    .hold_n_o     (hold_n),
    .fetch_en_o   (fetch_en),
    .fetch_zero_o (fetch_zero),
    .cause_o      (cause)
  );

  assign strap_pins = {strap_tri, strap_boot};

  rst_seq_strap #(.WIDTH(NUM_STRAPS)) u_strap (
    .clk    (clk),
    .cap_en (sync_release),
    .pins_i (strap_pins),
    .held_o (strap_held)
  );

  assign core_rst_n   = sync_rst_n & hold_n;
  assign periph_rst_n = sync_rst_n & hold_n;
  assign boot_mode    = strap_held[0];
  assign tri_mode     = strap_held[1];
  assign rst_cause    = cause;

endmodule

// File: rtl/rst_seq_chk.sv
`timescale 1ns/1ps
module rst_seq_chk
  import rst_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FETCH_DELAY = 80
) (
  input logic       clk,
  input logic       ext_rst_n,
  input logic       wdt_req,
  input logic       core_rst_n,
  input logic       periph_rst_n,
  input logic       fetch_en,
  input logic       fetch_zero,
  input logic       boot_mode,
  input logic       tri_mode,
  input logic [1:0] rst_cause
);

  // consecutive cycles with core reset released, saturating
  logic [15:0] up_cnt;
  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      up_cnt <= '0;
    end else if (!core_rst_n) begin
      up_cnt <= '0;
    end else if (up_cnt != 16'hFFFF) begin
      up_cnt <= up_cnt + 16'd1;
    end
  end

  // R1
  always @(posedge clk) begin
    if (!ext_rst_n) begin
      pin_hold_chk: assert (!core_rst_n && !periph_rst_n && !fetch_en);
    end
  end

  // R2
  rise_sync_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(core_rst_n) |-> ($past(ext_rst_n) && $past(ext_rst_n, 2)));

  // R3
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(fetch_en) |-> (up_cnt >= 16'(FETCH_DELAY - SYNC_STAGES)));

  // R4
  wdt_take_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (wdt_req && core_rst_n) |=> (!core_rst_n && !periph_rst_n && !fetch_en));

  // R7
  strap_keep_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (rst_cause == CAUSE_WDT) |-> $stable({boot_mode, tri_mode}));

  // R9
  cause_code_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (rst_cause == CAUSE_PIN) || (rst_cause == CAUSE_WDT));

  // R10
  zero_first_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(fetch_en) |-> fetch_zero);

  // R10
  zero_once_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    fetch_zero |=> !fetch_zero);

  // R1
  fetch_in_run_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    fetch_en |-> core_rst_n);

endmodule

bind rst_seq_top rst_seq_chk #(
  .SYNC_STAGES (SYNC_STAGES),
  .FETCH_DELAY (FETCH_DELAY)
) u_chk (
  .clk          (clk),
  .ext_rst_n    (ext_rst_n),
  .wdt_req      (wdt_req),
  .core_rst_n   (core_rst_n),
  .periph_rst_n (periph_rst_n),
  .fetch_en     (fetch_en),
  .fetch_zero   (fetch_zero),
  .boot_mode    (boot_mode),
  .tri_mode     (tri_mode),
  .rst_cause    (rst_cause)
);

// File: tb/rst_seq_top_tb.sv
`timescale 1ns/1ps
module rst_seq_top_tb;

  logic       clk = 1'b0;
  logic       ext_rst_n, wdt_req, strap_boot, strap_tri;
  logic       core_rst_n, periph_rst_n, fetch_en, fetch_zero;
  logic       boot_mode, tri_mode;
  logic [1:0] rst_cause;

  always #2.5 clk = ~clk;

  rst_seq_top u_dut (
    .clk          (clk),
    .ext_rst_n    (ext_rst_n),
    .wdt_req      (wdt_req),
    .strap_boot   (strap_boot),
    .strap_tri    (strap_tri),
    .core_rst_n   (core_rst_n),
    .periph_rst_n (periph_rst_n),
    .fetch_en     (fetch_en),
    .fetch_zero   (fetch_zero),
    .boot_mode    (boot_mode),
    .tri_mode     (tri_mode),
    .rst_cause    (rst_cause)
  );

  localparam logic [7:0] M_CORE  = 8'h80;
  localparam logic [7:0] M_PER   = 8'h40;
  localparam logic [7:0] M_FE    = 8'h20;
  localparam logic [7:0] M_FZ    = 8'h10;
  localparam logic [7:0] M_BOOT  = 8'h08;
  localparam logic [7:0] M_TRI   = 8'h04;
  localparam logic [7:0] M_CAUSE = 8'h03;

  logic [7:0] obs;
  assign obs = {core_rst_n, periph_rst_n, fetch_en, fetch_zero,
                boot_mode, tri_mode, rst_cause};

  typedef struct {
    int         at;
    logic [7:0] mask;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   cyc   = 0;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int at, input logic [7:0] m,
                           input logic [7:0] v, input string tag);
    exp_t e;
    e.at = at; e.mask = m; e.val = v; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: samples on the falling edge, inputs move 1 ns later
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at == cyc) begin
        total++;
        if ((obs & sbq[i].mask) !== (sbq[i].val & sbq[i].mask)) begin
          bad++;
          $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b",
                   sbq[i].tag, cyc, obs & sbq[i].mask,
                   sbq[i].val & sbq[i].mask, sbq[i].mask);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic at_cyc(input int n);
    while (cyc < n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R11 watchdog expired: actual=cyc %0d expected=end by 700", cyc);
    finish_run();
  end

  initial begin
    ext_rst_n  = 1'b1;
    wdt_req    = 1'b0;
    strap_boot = 1'b1;
    strap_tri  = 1'b0;
    #1 ext_rst_n = 1'b0;

    // reset state, R1
    expect_at(3, M_CORE | M_PER | M_FE | M_FZ, 8'h00, "R1");

    // pin release at cycle 6
    expect_at(7,  M_CORE | M_PER, 8'h00, "R2");
    expect_at(8,  M_CORE | M_PER, M_CORE | M_PER, "R2");
    expect_at(8,  M_BOOT | M_TRI, M_BOOT, "R6");
    expect_at(8,  M_CAUSE, 8'h01, "R9");
    expect_at(16, M_BOOT | M_TRI, M_BOOT, "R6");
    expect_at(85, M_FE, 8'h00, "R3");
    expect_at(86, M_FE | M_FZ, M_FE | M_FZ, "R3");
    expect_at(87, M_FE | M_FZ, M_FE, "R10");
    at_cyc(6);
    ext_rst_n = 1'b1;
    at_cyc(11);
    strap_boot = 1'b0;
    strap_tri  = 1'b1;

    // lone watchdog pulse at cycle 126
    expect_at(127, M_CORE | M_PER | M_FE, 8'h00, "R4");
    expect_at(127, M_CAUSE, 8'h02, "R9");
    expect_at(142, M_CORE | M_PER, 8'h00, "R4");
    expect_at(143, M_CORE | M_PER, M_CORE | M_PER, "R4");
    expect_at(143, M_BOOT | M_TRI, M_BOOT, "R7");
    expect_at(222, M_FE, 8'h00, "R5");
    expect_at(223, M_FE | M_FZ, M_FE | M_FZ, "R5");
    at_cyc(126);
    wdt_req = 1'b1;
    at_cyc(127);
    wdt_req = 1'b0;

    // watchdog at 326, again at 373 during the fetch delay
    expect_at(374, M_CORE, 8'h00, "R11");
    expect_at(390, M_CORE, M_CORE, "R11");
    expect_at(423, M_FE, 8'h00, "R11");
    expect_at(469, M_FE, 8'h00, "R11");
    expect_at(470, M_FE | M_FZ, M_FE | M_FZ, "R11");
    at_cyc(326);
    wdt_req = 1'b1;
    at_cyc(327);
    wdt_req = 1'b0;
    at_cyc(373);
    wdt_req = 1'b1;
    at_cyc(374);
    wdt_req = 1'b0;

    // watchdog at 523 with both strap pins high, then pin plus watchdog at 560
    expect_at(540, M_BOOT | M_TRI, M_BOOT, "R7");
    expect_at(561, M_CORE | M_PER, 8'h00, "R8");
    expect_at(561, M_CAUSE, 8'h01, "R8");
    expect_at(566, M_CORE | M_PER, M_CORE | M_PER, "R2");
    expect_at(566, M_BOOT | M_TRI | M_CAUSE, M_BOOT | M_TRI | 8'h01, "R8");
    expect_at(620, M_FE, 8'h00, "R11");
    expect_at(643, M_FE, 8'h00, "R11");
    expect_at(644, M_FE | M_FZ, M_FE | M_FZ, "R11");
    expect_at(645, M_FE | M_FZ, M_FE, "R10");
    at_cyc(518);
    strap_boot = 1'b1;
    strap_tri  = 1'b1;
    at_cyc(523);
    wdt_req = 1'b1;
    at_cyc(524);
    wdt_req = 1'b0;
    at_cyc(560);
    ext_rst_n = 1'b0;
    wdt_req   = 1'b1;
    #0.5;
    total++;
    if (core_rst_n !== 1'b0 || periph_rst_n !== 1'b0 || fetch_en !== 1'b0) begin
      bad++;
      $display("FAIL R1 async assert: actual=%b%b%b expected=000",
               core_rst_n, periph_rst_n, fetch_en);
    end
    at_cyc(561);
    wdt_req = 1'b0;
    at_cyc(564);
    ext_rst_n = 1'b1;

    at_cyc(700);
    foreach (sbq[i]) begin
      total++;
      bad++;
      $display("FAIL %s unchecked at cyc=%0d: actual=none expected=%b",
               sbq[i].tag, sbq[i].at, sbq[i].val);
    end
    finish_run();
  end

endmodule